// File: doc/BRIEF.md
# Strap-Configured SPI Target Shifter

This block is the serial front end of a host-interface bridge. It acts as an SPI target and moves whole bytes between the serial pins and a parallel side. The parallel side uses a valid/ready handshake in each direction. Bit order, clock polarity and clock phase are not held in registers. Three configuration straps set them, and the block latches the straps while reset is asserted.

The serial pins are much slower than the system clock. The serial clock is at most 8 Mbit/s, against a system clock of up to 80 MHz. Chip select, serial clock and serial data in each pass through a two-flop synchroniser into the system clock domain. Edge detection on the synchronised clock then produces sample and drive strobes for the datapath.

The block responds only when the global mode straps select serial operation. The 3-bit mode strap must equal 110b and the serial-type strap must equal 0. In every other strap setting it ignores its pins and keeps its output disabled. The serial output has a separate output-enable pin so that a pad can tri-state it.

Top module: `spi_strap_target`

## Requirements
- R1: The block is active only when `modeStrap` equals 3'b110 and `serTypeStrap` equals 0, both latched during reset. When inactive, `sdoOe` stays 0, no byte is delivered on `rxValid`, and a byte held in the transmit buffer is not consumed (`txReady` stays 0).
- R2: `sdoOe` is 0 whenever `csN` is high. It is 1 while `csN` is low in active mode.
- R3: With `cfgStrap[2]` = 0, bytes are shifted most significant bit first in both directions.
- R4: With `cfgStrap[2]` = 1, bytes are shifted least significant bit first in both directions.
- R5: `cfgStrap[1]` is clock polarity. With 1 the serial clock idles high and its first edge is falling. With 0 it idles low and its first edge is rising.
- R6: With `cfgStrap[0]` = 0, input data is sampled on odd clock edges (1st, 3rd, …). The first output bit is valid after chip select falls and before the first edge, and the output changes on even edges.
- R7: With `cfgStrap[0]` = 1, input data is sampled on even clock edges. Output bits are presented on odd edges, starting with the first edge.
- R8: The straps are captured only while `rstN` is low. Changing them after reset has no effect on shifting.
- R9: Raising `csN` clears the bit counter. A partly received byte is discarded, and the next session starts at bit 0.
- R10: A received byte appears on `rxData` with `rxValid` high. Both hold steady until `rxReady` is seen high, and then `rxValid` clears.
- R11: `txReady` is high when the transmit buffer is empty. A byte is taken when `txValid` and `txReady` are both high, and it is moved into the shifter at the next byte boundary.
- R12: If the transmit buffer is empty at a byte boundary, 0x00 is shifted out and `txUnderrun` is set. It stays set until the next byte is accepted from the parallel side.
- R13: After reset, `rxValid` = 0, `txReady` = 1, `txUnderrun` = 0 and `sdoOe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; straps are latched while low |
| modeStrap | input | 3 | Global mode strap; 3'b110 selects serial |
| serTypeStrap | input | 1 | Serial type strap; 0 selects SPI |
| cfgStrap | input | 3 | Bit 2 LSB-first, bit 1 polarity, bit 0 phase |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdoOe | output | 1 | Output enable for the serial data pad |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte valid |
| txReady | output | 1 | Transmit buffer empty |
| txUnderrun | output | 1 | Set when a byte boundary found no byte |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | Received byte valid |
| rxReady | input | 1 | Parallel side has taken the byte |

## Verification
The assertions assume that the straps do not change while reset is held low. They also assume that each level on `csN`, `sck` and `sdi` lasts well beyond the synchroniser depth, so that no serial edge is lost or merged in the system clock domain.

The stimulus holds the straps constant through every reset pulse. It toggles the serial clock only every 20 system cycles, and it moves chip select only while the serial clock is at its idle level. Every strap combination the tests use is chosen before reset is released.

// File: rtl/spi_strap_pkg.sv
package spi_strap_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic load;    // move buffer byte (or 0x00) into transmit shifter
    logic shift;   // advance transmit shifter by one bit
    logic sample;  // shift one received bit in
    logic last;    // the sampled bit completes a byte
    logic sdiBit;  // synchronised serial input bit
  } spiStrobes_t;
endpackage

// File: rtl/spi_strap_ctrl.sv
module spi_strap_ctrl
  import spi_strap_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  modeStrap,
  input  logic        serTypeStrap,
  input  logic [2:0]  cfgStrap,
  input  logic        csN,
  input  logic        sck,
  input  logic        sdi,
  output spiStrobes_t strb,
  output logic        active,
  output logic        lsbFirst
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DW - 1);

  logic             activeQ, lsbQ, cpolQ, cphaQ;
  logic [SYNC_STAGES-1:0] csPipe, sckPipe, sdiPipe;
  logic             csD, sckD;
  logic [CNT_W-1:0] bitCnt;

  // strap capture happens only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= (modeStrap == 3'b110) && !serTypeStrap;
      lsbQ    <= cfgStrap[2];
      cpolQ   <= cfgStrap[1];
      cphaQ   <= cfgStrap[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      sdiPipe <= '0;
      csD     <= 1'b1;
      sckD    <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sck};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      csD     <= csPipe[SYNC_STAGES-1];
      sckD    <= sckPipe[SYNC_STAGES-1];
    end
  end

  logic csS, sckS, sckRise, sckFall, leadEv, trailEv, sampleEv, driveEv, csFall, live;
  always_comb begin
    csS      = csPipe[SYNC_STAGES-1];
    sckS     = sckPipe[SYNC_STAGES-1];
    sckRise  = sckS && !sckD;
    sckFall  = !sckS && sckD;
    leadEv   = cpolQ ? sckFall : sckRise;
    trailEv  = cpolQ ? sckRise : sckFall;
    sampleEv = cphaQ ? trailEv : leadEv;
    driveEv  = cphaQ ? leadEv : trailEv;
    csFall   = csD && !csS;
    live     = activeQ && !csS;

    strb.sample = live && sampleEv;
    strb.last   = live && sampleEv && (bitCnt == LAST_CNT);
    strb.load   = live && ((!cphaQ && csFall) || (driveEv && bitCnt == '0));
    strb.shift  = live && driveEv && (bitCnt != '0);
    strb.sdiBit = sdiPipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           bitCnt <= '0;
    else if (!live)      bitCnt <= '0;
    else if (strb.sample) bitCnt <= (bitCnt == LAST_CNT) ? '0 : bitCnt + 1'b1;
  end

  assign active   = activeQ;
  assign lsbFirst = lsbQ;

  p_strap_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(activeQ) && $stable(lsbQ) && $stable(cpolQ) && $stable(cphaQ)));

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csS) |=> (bitCnt == '0));
endmodule

// File: rtl/spi_strap_datapath.sv
module spi_strap_datapath
  import spi_strap_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  spiStrobes_t   strb,
  input  logic          lsbFirst,
  input  logic [DW-1:0] txData,
  input  logic          txValid,
  output logic          txReady,
  output logic          txUnderrun,
  output logic [DW-1:0] rxData,
  output logic          rxValid,
  input  logic          rxReady,
  output logic          sdoBit
);
  logic [DW-1:0] txBuf, txShift, rxShift, rxNext;
  logic          txFull, txAccept;

  always_comb begin
    txAccept = txValid && !txFull;
    rxNext   = lsbFirst ? {strb.sdiBit, rxShift[DW-1:1]} : {rxShift[DW-2:0], strb.sdiBit};
    sdoBit   = lsbFirst ? txShift[0] : txShift[DW-1];
    txReady  = !txFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf      <= '0;
      txFull     <= 1'b0;
      txShift    <= '0;
      txUnderrun <= 1'b0;
    end else begin
      if (txAccept) begin
        txBuf      <= txData;
        txFull     <= 1'b1;
        txUnderrun <= 1'b0;
      end
      if (strb.load) begin
        if (txFull) begin
          txShift <= txBuf;
          txFull  <= 1'b0;
        end else begin
          txShift    <= '0;
          txUnderrun <= 1'b1;
        end
      end else if (strb.shift) begin
        txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strb.sample) rxShift <= rxNext;
      if (strb.last) begin
        rxData  <= rxNext;
        rxValid <= 1'b1;
      end else if (rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  p_rx_from_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $past(strb.last));

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strb.last) |=> (rxValid && $stable(rxData)));

  p_underrun_src_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txUnderrun) |-> $past(strb.load && !txFull));
endmodule

// File: rtl/spi_strap_target.sv
module spi_strap_target
  import spi_strap_pkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    modeStrap,
  input  logic          serTypeStrap,
  input  logic [2:0]    cfgStrap,
  input  logic          csN,
  input  logic          sck,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdoOe,
  input  logic [DW-1:0] txData,
  input  logic          txValid,
  output logic          txReady,
  output logic          txUnderrun,
  output logic [DW-1:0] rxData,
  output logic          rxValid,
  input  logic          rxReady
);
  spiStrobes_t strb;
  logic        active, lsbFirst, sdoBit;

  spi_strap_ctrl #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .serTypeStrap(serTypeStrap),
    .cfgStrap(cfgStrap), .csN(csN), .sck(sck), .sdi(sdi),
    .strb(strb), .active(active), .lsbFirst(lsbFirst)
  );

  spi_strap_datapath #(.DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lsbFirst(lsbFirst),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txUnderrun(txUnderrun),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady), .sdoBit(sdoBit)
  );

  assign sdoOe = active && !csN;
  assign sdo   = sdoOe && sdoBit;

  p_no_rx_inactive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!rxValid && !strb.load));
endmodule

// File: tb/spi_strap_target_tb_top.sv
module spi_strap_target_tb_top;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeStrap = 3'b110;
  logic       serTypeStrap = 1'b0;
  logic [2:0] cfgStrap = 3'b000;
  logic       csN = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic       sdo, sdoOe, txReady, txUnderrun, rxValid;
  logic [7:0] txData = '0, rxData;
  logic       txValid = 1'b0, rxReady = 1'b0;

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  bLsb = 0, bCpol = 0, bCpha = 0;
  logic oeSeen;

  always #10 clk = ~clk;

  spi_strap_target dut_i (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .serTypeStrap(serTypeStrap),
    .cfgStrap(cfgStrap), .csN(csN), .sck(sck), .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txUnderrun(txUnderrun),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] mode, input logic typ, input logic [2:0] cfg);
    @(negedge clk);
    rstN = 1'b0; modeStrap = mode; serTypeStrap = typ; cfgStrap = cfg;
    bLsb = cfg[2]; bCpol = cfg[1]; bCpha = cfg[0];
    csN = 1'b1; sck = cfg[1]; sdi = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    txData = b; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic popRx();
    @(negedge clk); rxReady = 1'b1;
    @(negedge clk); rxReady = 1'b0;
  endtask

  function automatic int pos(input int i);
    return bLsb ? i : 7 - i;
  endfunction

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    @(negedge clk);
    csN = 1'b0;
    if (!bCpha) sdi = mo[pos(0)];
    waitClk(H);
    oeSeen = sdoOe;
    for (int i = 0; i < nbits; i++) begin
      if (bCpha) begin
        sck = ~sck; sdi = mo[pos(i)]; waitClk(H);
        mi[pos(i)] = sdo; sck = ~sck; waitClk(H);
      end else begin
        mi[pos(i)] = sdo; sck = ~sck; waitClk(H);
        sck = ~sck; if (i < 7) sdi = mo[pos(i + 1)]; waitClk(H);
      end
    end
    csN = 1'b1;
    waitClk(H);
  endtask

  task automatic tReset();
    doReset(3'b110, 1'b0, 3'b000);
    check(rxValid == 0, "R13 rxValid", rxValid, 0);
    check(txReady == 1, "R13 txReady", txReady, 1);
    check(txUnderrun == 0, "R13 txUnderrun", txUnderrun, 0);
    check(sdoOe == 0, "R13 sdoOe", sdoOe, 0);
  endtask

  task automatic tByte(input logic [2:0] cfg, input logic [7:0] mo, input logic [7:0] so, input string req);
    logic [7:0] mi;
    doReset(3'b110, 1'b0, cfg);
    pushTx(so);
    check(txReady == 0, {req, " R11 buffer full"}, txReady, 0);
    xfer(mo, 8, mi);
    check(oeSeen == 1, {req, " R2 oe low cs"}, oeSeen, 1);
    check(sdoOe == 0, {req, " R2 oe high cs"}, sdoOe, 0);
    check(mi == so, {req, " tx data"}, mi, so);
    check(rxValid == 1 && rxData == mo, {req, " rx data"}, rxData, mo);
    waitClk(10);
    check(rxValid == 1 && rxData == mo, {req, " R10 hold"}, rxData, mo);
    popRx();
    check(rxValid == 0, {req, " R10 clear"}, rxValid, 0);
  endtask

  task automatic tPartial();
    logic [7:0] mi;
    doReset(3'b110, 1'b0, 3'b000);
    xfer(8'hF0, 3, mi);
    check(rxValid == 0, "R9 partial dropped", rxValid, 0);
    xfer(8'h81, 8, mi);
    check(rxValid == 1 && rxData == 8'h81, "R9 realigned", rxData, 8'h81);
    popRx();
  endtask

  task automatic tUnderrun();
    logic [7:0] mi;
    doReset(3'b110, 1'b0, 3'b001);
    xfer(8'h55, 8, mi);
    check(mi == 8'h00, "R12 zero out", mi, 0);
    check(txUnderrun == 1, "R12 flag set", txUnderrun, 1);
    pushTx(8'h77);
    check(txUnderrun == 0, "R12 flag cleared", txUnderrun, 0);
    xfer(8'h11, 8, mi);
    check(mi == 8'h77, "R11 byte sent", mi, 8'h77);
    check(txReady == 1, "R11 ready after load", txReady, 1);
    popRx();
  endtask

  task automatic tStrapLate();
    logic [7:0] mi;
    doReset(3'b110, 1'b0, 3'b000);
    @(negedge clk); cfgStrap = 3'b111; modeStrap = 3'b000;
    pushTx(8'hC3);
    xfer(8'h2D, 8, mi);
    check(mi == 8'hC3, "R8 tx unaffected", mi, 8'hC3);
    check(rxValid == 1 && rxData == 8'h2D, "R8 rx unaffected", rxData, 8'h2D);
    popRx();
  endtask

  task automatic tInactive();
    logic [7:0] mi;
    doReset(3'b100, 1'b0, 3'b000);
    pushTx(8'h5A);
    xfer(8'hE7, 8, mi);
    check(oeSeen == 0, "R1 oe off wrong mode", oeSeen, 0);
    check(rxValid == 0, "R1 no rx wrong mode", rxValid, 0);
    check(txReady == 0, "R1 tx kept wrong mode", txReady, 0);
    doReset(3'b110, 1'b1, 3'b000);
    pushTx(8'h5A);
    xfer(8'hE7, 8, mi);
    check(oeSeen == 0, "R1 oe off wrong type", oeSeen, 0);
    check(rxValid == 0, "R1 no rx wrong type", rxValid, 0);
    check(txReady == 0, "R1 tx kept wrong type", txReady, 0);
  endtask

  initial begin
    tReset();
    tByte(3'b000, 8'h3C, 8'hA5, "R3 R6 msb mode0");
    tByte(3'b100, 8'h1E, 8'h96, "R4 lsb mode0");
    tByte(3'b010, 8'hB2, 8'h4D, "R5 R6 cpol1 cpha0");
    tByte(3'b001, 8'h69, 8'hC1, "R7 cpol0 cpha1");
    tByte(3'b111, 8'h0F, 8'h83, "R4 R5 R7 lsb mode3");
    tPartial();
    tUnderrun();
    tStrapLate();
    tInactive();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule